// File: doc/BRIEF.md
# Asynchronous Byte-Lane SRAM Sequencer

This block sits between a single-cycle request port inside the chip and an external 16-bit static RAM that has no clock. Each accepted request becomes one complete access on the RAM pins. The block holds a 19-bit word address and drives an active-low select, two active-low lane selects, an active-low write strobe and an active-low read enable. It also drives or releases the data bus. Every pulse width, access window and bus turnaround is a number of clock cycles. These numbers come from nanosecond parameters and the clock period, rounded up.

Each request carries a two-bit lane mask, so a write can touch one byte and leave the other unchanged. A read returns only the selected bytes. After a write the block always inserts one quiet cycle. After a read it waits out the RAM's bus release time before it takes the next request. A power-down input parks the RAM deselected so that its contents are retained. When the input is released, the block waits out the supply recovery time before it takes requests again.

Top module: `sram_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_be_n` is 2'b11, `mem_dq_oe` is 0, `rd_valid` is 0, and `req_ready` is 1 while `pwr_down` is 0.
- R2: On an accepted write, `mem_we_n`, `mem_cs_n` and the enabled lane selects fall in the same cycle and stay low for exactly WR_CYC cycles. WR_CYC is the ceiling of the largest of 55, 50, 45 and 25 ns divided by the clock period, which gives 6 at 10 ns. `mem_addr` holds the request address throughout. `req_be[0]`=1 drives `mem_be_n[0]` low and selects data bits 7:0. `req_be[1]`=1 drives `mem_be_n[1]` low and selects bits 15:8.
- R3: `mem_dq_oe` is 1 only in the write-strobe-low cycles and the single cycle after them. In that following cycle every strobe is high. `mem_dq_out` carries the request data throughout. `mem_dq_oe` is never 1 while `mem_oe_n` is 0.
- R4: After a write is accepted, `req_ready` stays low for exactly WR_CYC+2 cycles. The second of the two extra cycles has all strobes high and the bus released.
- R5: On an accepted read, `mem_oe_n` and `mem_cs_n` are low and `mem_we_n` is high for exactly RD_CYC cycles. RD_CYC is the ceiling of 55 ns over the period, which gives 6. `rd_valid` is then high for one cycle, in the cycle right after the window. It carries the bus value sampled in the window's last cycle.
- R6: On a read, a lane whose `req_be` bit is 0 keeps its `mem_be_n` bit high. The matching byte of `rd_data` is 0, whatever the bus shows.
- R7: After a read is accepted, `req_ready` stays low for RD_CYC plus TURN_CYC cycles. TURN_CYC is the ceiling of 20 ns over the period, which gives 2. A following write therefore cannot drive data until TURN_CYC cycles after `mem_oe_n` rises.
- R8: While `pwr_down` is 1 and the block is idle, `req_ready` is 0 and `mem_cs_n` is 1. A request presented during that time is never performed.
- R9: After `pwr_down` falls, `req_ready` stays 0 for exactly REC_CYC cycles and then rises. REC_CYC is the ceiling of PD_REC_NS over the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Lane enables, bit i selects byte i |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data, disabled lanes zero |
| pwr_down | input | 1 | Retention request |
| mem_addr | output | ADDR_W | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_be_n | output | DATA_W/8 | RAM lane selects, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM read enable, active low |
| mem_dq_out | output | DATA_W | Data toward the RAM |
| mem_dq_oe | output | 1 | Data driver enable |
| mem_dq_in | input | DATA_W | Data from the RAM |

## Verification
The bench models the RAM, which stores only the lanes whose selects are low, and drives 8'hA5 on unselected lanes. Writes to a single lane would then corrupt the other byte of the word if the lane mapping were swapped or ignored. Reads of a single lane would show 8'hA5 instead of 0 if masking were missing. The bench counts strobe, driver and ready cycles for each access. A pulse that is one cycle short, a driver that is held into the quiet cycle, or a skipped bus-turnaround wait after a read then shows up as a wrong count. A write request held during power-down is followed by a read-back and a count of the recovery cycles. A design that took the request, or that ended recovery early, would fail one of them.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD,
      ST_TURN,
      ST_WR,
      ST_HOLD,
      ST_GAP,
      ST_PDN,
      ST_RECOV
   } seq_state_e;

   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int min1(input int a);
      return (a < 1) ? 1 : a;
   endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_rdlane.sv
module sram_seq_rdlane #(
   parameter int LANES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture,
   input  logic [LANES-1:0]   lane_en,
   input  logic [LANES*8-1:0] bus_in,
   output logic [LANES*8-1:0] data_out,
   output logic               data_vld
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) data_vld <= 1'b0;
      else        data_vld <= capture;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            data_out[g*8 +: 8] <= '0;
         end else if (capture) begin
            data_out[g*8 +: 8] <= lane_en[g] ? bus_in[g*8 +: 8] : 8'h00;
         end
      end
   end

endmodule

// File: rtl/sram_seq.sv
module sram_seq
   import sram_seq_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 16,
   parameter int CLK_NS      = 10,
   parameter int RD_ACC_NS   = 55,
   parameter int OE_ACC_NS   = 30,
   parameter int WR_CYCLE_NS = 55,
   parameter int WR_PULSE_NS = 45,
   parameter int WR_SEL_NS   = 50,
   parameter int WR_DATA_NS  = 25,
   parameter int BUS_REL_NS  = 20,
   parameter int PD_REC_NS   = 5_000_000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   output logic                 req_ready,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [DATA_W-1:0]    req_wdata,
   input  logic [DATA_W/8-1:0]  req_be,
   output logic                 rd_valid,
   output logic [DATA_W-1:0]    rd_data,
   input  logic                 pwr_down,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic                 mem_cs_n,
   output logic [DATA_W/8-1:0]  mem_be_n,
   output logic                 mem_we_n,
   output logic                 mem_oe_n,
   output logic [DATA_W-1:0]    mem_dq_out,
   output logic                 mem_dq_oe,
   input  logic [DATA_W-1:0]    mem_dq_in
);

   localparam int LANES    = DATA_W / 8;
   localparam int RD_CYC   = min1(max2(ceil_div(RD_ACC_NS, CLK_NS), ceil_div(OE_ACC_NS, CLK_NS)));
   localparam int WR_CYC   = min1(max2(max2(ceil_div(WR_CYCLE_NS, CLK_NS), ceil_div(WR_PULSE_NS, CLK_NS)),
                                       max2(ceil_div(WR_SEL_NS, CLK_NS), ceil_div(WR_DATA_NS, CLK_NS))));
   localparam int TURN_CYC = min1(ceil_div(BUS_REL_NS, CLK_NS));
   localparam int REC_CYC  = min1(ceil_div(PD_REC_NS, CLK_NS));
   localparam int CNT_MAX  = max2(max2(RD_CYC, WR_CYC), max2(TURN_CYC, REC_CYC));
   localparam int CNT_W    = $clog2(CNT_MAX + 1);

   if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_bad_data_w
      $error("sram_seq: DATA_W must be a positive multiple of 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr_w
      $error("sram_seq: ADDR_W must be at least 1");
   end
   if (CLK_NS < 1) begin : g_bad_clk
      $error("sram_seq: CLK_NS must be at least 1");
   end

   seq_state_e          state_q, state_nxt;
   logic                tmr_load, tmr_done;
   logic [CNT_W-1:0]    tmr_val;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   wdata_q;
   logic [LANES-1:0]    be_q;
   logic                accept;

   assign accept = (state_q == ST_IDLE) && !pwr_down && req_valid;

   always_comb begin
      state_nxt = state_q;
      tmr_load  = 1'b0;
      tmr_val   = '0;
      case (state_q)
         ST_IDLE: begin
            if (pwr_down) begin
               state_nxt = ST_PDN;
            end else if (req_valid) begin
               tmr_load = 1'b1;
               if (req_write) begin
                  state_nxt = ST_WR;
                  tmr_val   = CNT_W'(WR_CYC - 1);
               end else begin
                  state_nxt = ST_RD;
                  tmr_val   = CNT_W'(RD_CYC - 1);
               end
            end
         end
         ST_RD: begin
            if (tmr_done) begin
               state_nxt = ST_TURN;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(TURN_CYC - 1);
            end
         end
         ST_TURN:  if (tmr_done) state_nxt = ST_IDLE;
         ST_WR:    if (tmr_done) state_nxt = ST_HOLD;
         ST_HOLD:  state_nxt = ST_GAP;
         ST_GAP:   state_nxt = ST_IDLE;
         ST_PDN: begin
            if (!pwr_down) begin
               state_nxt = ST_RECOV;
               tmr_load  = 1'b1;
               tmr_val   = CNT_W'(REC_CYC - 1);
            end
         end
         ST_RECOV: begin
            if (pwr_down)      state_nxt = ST_PDN;
            else if (tmr_done) state_nxt = ST_IDLE;
         end
         default: state_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         be_q    <= '0;
      end else begin
         state_q <= state_nxt;
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
         end
      end
   end

   sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   sram_seq_rdlane #(.LANES(LANES)) u_rdlane (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  ((state_q == ST_RD) && tmr_done),
      .lane_en  (be_q),
      .bus_in   (mem_dq_in),
      .data_out (rd_data),
      .data_vld (rd_valid)
   );

   logic in_access;
   assign in_access  = (state_q == ST_RD) || (state_q == ST_WR);

   assign req_ready  = (state_q == ST_IDLE) && !pwr_down;
   assign mem_addr   = addr_q;
   assign mem_cs_n   = !in_access;
   assign mem_be_n   = in_access ? ~be_q : '1;
   assign mem_we_n   = (state_q != ST_WR);
   assign mem_oe_n   = (state_q != ST_RD);
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = (state_q == ST_WR) || (state_q == ST_HOLD);

endmodule

// File: rtl/sram_seq_chk.sv
module sram_seq_chk #(
   parameter int ADDR_W = 19,
   parameter int LANES  = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              pwr_down,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_cs_n,
   input logic [LANES-1:0]  mem_be_n,
   input logic              mem_we_n,
   input logic              mem_oe_n,
   input logic              mem_dq_oe
);

   // R2: write strobe never falls after the chip select
   p_we_with_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n) |-> $fell(mem_cs_n));

   // R2: address unchanged across the strobe window
   p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

   // R3: no driving while the RAM may drive
   p_no_fight_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   // R3: driver turns on only together with the strobe
   p_drv_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_dq_oe && !$past(mem_dq_oe)) |-> (!mem_we_n && $past(mem_we_n)));

   // R3: at most one hold cycle after the strobe rises
   p_drv_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_n && $past(mem_we_n)) |-> !mem_dq_oe);

   // R4: idle means quiet pins
   p_ready_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && (mem_be_n == '1)));

   // R5: read strobe is a single cycle tied to the end of the window
   p_rdv_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);
   p_rdv_at_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $rose(mem_oe_n));

   // R7: the bus is left free in the cycle after a read
   p_turn_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |=> (!mem_dq_oe && mem_we_n));

   // R8: no new access starts during power-down
   p_pdn_noacc_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down && mem_cs_n) |=> mem_cs_n);
   p_pdn_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> !req_ready);

endmodule

bind sram_seq sram_seq_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .pwr_down  (pwr_down),
   .rd_valid  (rd_valid),
   .mem_addr  (mem_addr),
   .mem_cs_n  (mem_cs_n),
   .mem_be_n  (mem_be_n),
   .mem_we_n  (mem_we_n),
   .mem_oe_n  (mem_oe_n),
   .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_seq_tb.sv
module sram_seq_tb;

   localparam int AW       = 19;
   localparam int DW       = 16;
   localparam int PD_NS    = 300;
   localparam int WR_CYC   = (55 + 9) / 10;
   localparam int RD_CYC   = (55 + 9) / 10;
   localparam int TURN_CYC = (20 + 9) / 10;
   localparam int REC_CYC  = (PD_NS + 9) / 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    req_be = '0;
   logic          rd_valid;
   logic [DW-1:0] rd_data;
   logic          pwr_down = 1'b0;
   logic [AW-1:0] mem_addr;
   logic          mem_cs_n;
   logic [1:0]    mem_be_n;
   logic          mem_we_n;
   logic          mem_oe_n;
   logic [DW-1:0] mem_dq_out;
   logic          mem_dq_oe;
   logic [DW-1:0] mem_dq_in;

   int checks = 0;
   int fails  = 0;

   logic [DW-1:0] ram    [0:255];
   logic [DW-1:0] shadow [0:255];

   always #5 clk = ~clk;

   sram_seq #(.PD_REC_NS(PD_NS)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_valid(rd_valid), .rd_data(rd_data), .pwr_down(pwr_down), .mem_addr(mem_addr),
      .mem_cs_n(mem_cs_n), .mem_be_n(mem_be_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // RAM model: stores selected lanes while strobes overlap
   always @(negedge clk) begin
      if (!mem_cs_n && !mem_we_n && mem_dq_oe) begin
         if (!mem_be_n[0]) ram[mem_addr[7:0]][7:0]  <= mem_dq_out[7:0];
         if (!mem_be_n[1]) ram[mem_addr[7:0]][15:8] <= mem_dq_out[15:8];
      end
   end

   always_comb begin
      mem_dq_in = 16'hA5A5;
      if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
         if (!mem_be_n[0]) mem_dq_in[7:0]  = ram[mem_addr[7:0]][7:0];
         if (!mem_be_n[1]) mem_dq_in[15:8] = ram[mem_addr[7:0]][15:8];
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_cs_n === 1'b1, "R1", "cs_n", int'(mem_cs_n), 1);
      chk(mem_we_n === 1'b1, "R1", "we_n", int'(mem_we_n), 1);
      chk(mem_oe_n === 1'b1, "R1", "oe_n", int'(mem_oe_n), 1);
      chk(mem_be_n === 2'b11, "R1", "be_n", int'(mem_be_n), 3);
      chk(mem_dq_oe === 1'b0, "R1", "dq_oe", int'(mem_dq_oe), 0);
      chk(rd_valid === 1'b0, "R1", "rd_valid", int'(rd_valid), 0);
      chk(req_ready === 1'b1, "R1", "ready", int'(req_ready), 1);
   endtask

   task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [1:0] be);
      int we_cnt = 0, drv_cnt = 0, busy = 0, we_first = -1, cs_first = -1;
      int bad_addr = 0, bad_be = 0, bad_d = 0, fight = 0;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 60; i++) begin
         if (req_ready) break;
         busy++;
         if (!mem_we_n) begin
            we_cnt++;
            if (we_first < 0) we_first = i;
            if (mem_addr !== a) bad_addr++;
            if (mem_be_n !== ~be) bad_be++;
         end
         if (!mem_cs_n && cs_first < 0) cs_first = i;
         if (mem_dq_oe) begin
            drv_cnt++;
            if (mem_dq_out !== d) bad_d++;
            if (!mem_oe_n) fight++;
         end
         @(negedge clk);
      end
      chk(we_cnt == WR_CYC, "R2", "write strobe cycles", we_cnt, WR_CYC);
      chk(we_first == 0 && cs_first == 0, "R2", "strobe/select start", we_first, cs_first);
      chk(bad_addr == 0, "R2", "address unstable cycles", bad_addr, 0);
      chk(bad_be == 0, "R2", "lane select mismatches", bad_be, 0);
      chk(drv_cnt == WR_CYC + 1, "R3", "driver cycles", drv_cnt, WR_CYC + 1);
      chk(bad_d == 0 && fight == 0, "R3", "data/contention errors", bad_d + fight, 0);
      chk(busy == WR_CYC + 2, "R4", "write busy cycles", busy, WR_CYC + 2);
      if (be[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[7:0]][15:8] = d[15:8];
   endtask

   task automatic t_read(input logic [AW-1:0] a, input logic [1:0] be);
      int oe_cnt = 0, busy = 0, rv_cnt = 0, rv_idx = -1, bad_ctl = 0;
      logic [DW-1:0] got = '0, exp;
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 60; i++) begin
         if (req_ready) break;
         busy++;
         if (!mem_oe_n) begin
            oe_cnt++;
            if (mem_cs_n || !mem_we_n || mem_be_n !== ~be || mem_addr !== a) bad_ctl++;
         end
         if (rd_valid) begin
            rv_cnt++; rv_idx = i; got = rd_data;
         end
         @(negedge clk);
      end
      exp = shadow[a[7:0]];
      if (!be[0]) exp[7:0]  = 8'h00;
      if (!be[1]) exp[15:8] = 8'h00;
      chk(oe_cnt == RD_CYC, "R5", "read window cycles", oe_cnt, RD_CYC);
      chk(bad_ctl == 0, "R6", "read control mismatches", bad_ctl, 0);
      chk(rv_cnt == 1 && rv_idx == RD_CYC, "R5", "rd_valid position", rv_idx, RD_CYC);
      chk(got === exp, "R6", "read data", int'(got), int'(exp));
      chk(busy == RD_CYC + TURN_CYC, "R7", "read busy cycles", busy, RD_CYC + TURN_CYC);
   endtask

   task automatic t_power(input logic [AW-1:0] a);
      int bad = 0, busy = 0;
      @(negedge clk);
      pwr_down = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = 16'hDEAD; req_be = 2'b11;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (req_ready || !mem_cs_n || !mem_we_n || mem_dq_oe) bad++;
      end
      chk(bad == 0, "R8", "activity during power-down", bad, 0);
      req_valid = 1'b0;
      pwr_down = 1'b0;
      for (int i = 0; i < REC_CYC + 20; i++) begin
         @(negedge clk);
         if (req_ready) break;
         busy++;
      end
      chk(busy == REC_CYC, "R9", "recovery cycles", busy, REC_CYC);
      t_read(a, 2'b11);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         ram[i] = '0;
         shadow[i] = '0;
      end
      t_reset();
      t_write(19'h70012, 16'hBEEF, 2'b11);
      t_read(19'h70012, 2'b11);
      t_write(19'h70012, 16'h1234, 2'b10);
      t_read(19'h70012, 2'b11);
      t_write(19'h70012, 16'h9956, 2'b01);
      t_read(19'h70012, 2'b01);
      t_read(19'h70012, 2'b10);
      t_write(19'h000A5, 16'hC3C3, 2'b11);
      t_write(19'h7FFFF, 16'h0F0F, 2'b11);
      t_read(19'h000A5, 2'b11);
      t_read(19'h7FFFF, 2'b11);
      t_power(19'h70012);
      t_write(19'h000A5, 16'h5AA5, 2'b10);
      t_read(19'h000A5, 2'b11);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule